// File: doc/BRIEF.md
# Double-Precision Subtract Datapath (Unrounded)

This block computes x minus y for two 64-bit binary floating-point operands and hands an unrounded result to a downstream rounder. Each operand is first sorted into one of six classes (zero, subnormal, normal, infinity, quiet NaN, signalling NaN). Any pair that contains a NaN, an infinity or a zero is settled at once by a fixed priority table and leaves the block as a finished 64-bit pattern on a bypass bus, together with an invalid-operation flag.

When both operands are finite and nonzero, the sign of y is inverted and the pair goes down an add path. Subnormals are first brought to normal form by a leading-zero count and a left shift, which takes the exponent below one. Both significands then gain three low bits (guard, round, sticky). The operand with the smaller exponent is shifted right with sticky collection, and the magnitudes are added or subtracted. The result is then normalized: one right step on a carry-out, or a leading-zero count and a single barrel shift after a cancellation. The output is a sign, a signed biased exponent and a 56-bit significand with its leading one at bit 55.

All results are captured in one output register, so a result appears one clock after it is presented. The rounding-mode input is used only to pick the sign of an exact zero.

Top module: `fpsub_core`

## Requirements
- R1: A signalling NaN is an operand whose exponent is all ones, whose fraction is nonzero and whose fraction bit 51 is 0. If y is one and x is not, the bypass result is y with fraction bit 51 forced to 1. If x is one, whatever y is, the bypass result is x with bit 51 forced to 1. In both cases the invalid flag is raised.
- R2: A quiet NaN has fraction bit 51 set. When y is a quiet NaN and x is not a NaN, the bypass result is y unchanged. When x is a quiet NaN and y is not a signalling NaN, the bypass result is x unchanged. Neither case raises invalid.
- R3: Infinity minus infinity of opposite signs returns x. With equal signs it raises invalid and returns 0x7FF8000000000000. A finite operand minus an infinity gives an infinity whose sign is the inverse of y's sign. An infinity minus a finite operand returns x.
- R4: Zero minus zero of opposite signs returns x. With equal signs the result is zero, and it is negative only when rnd_mode equals 3 (round toward minus infinity; 0 = nearest, 1 = toward zero, 2 = toward plus infinity).
- R5: A nonzero finite operand minus a zero returns x. A zero minus a nonzero finite operand returns y with bit 63 inverted.
- R6: A subnormal operand is normalized before alignment, so its leading one sits at the hidden position and its biased exponent becomes 1 minus the shift amount.
- R7: The operand with the smaller exponent is shifted right by the exponent difference. Any one shifted out is ORed into bit 0, and a difference of 56 or more leaves only that sticky bit.
- R8: When the effective signs agree, the magnitudes are added. A carry out of bit 55 shifts the sum right once, keeps the lost bit in bit 0, and raises the exponent by one. The sign is x's sign.
- R9: When the effective signs differ, the smaller magnitude is subtracted from the larger and the result takes the larger operand's effective sign. The difference is shifted left until bit 55 is 1, and the exponent falls by the same amount.
- R10: An exact cancellation of finite operands leaves as a bypass zero, negative only when rnd_mode equals 3.
- R11: Reset clears out_valid. A result presented with in_valid high appears with out_valid high after exactly one rising clock edge. When in_valid is low, out_valid is low on the next cycle.
- R12: res_invalid is raised only in the cases named in R1 and R3, and always with res_special high. A non-special result carries res_special low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_x | input | 64 | Minuend, binary64 |
| op_y | input | 64 | Subtrahend, binary64 |
| rnd_mode | input | 2 | Rounding mode; only the value 3 is acted on |
| out_valid | output | 1 | Registered result valid |
| res_sign | output | 1 | Sign of the unrounded result |
| res_exp | output | 13 | Signed biased exponent of the unrounded result |
| res_sig | output | 56 | Significand: leading one at bit 55, guard/round/sticky in bits 2..0 |
| res_special | output | 1 | res_bits holds a finished result and the other fields are to be ignored |
| res_bits | output | 64 | Finished binary64 result for special pairs and exact zeros |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
Two functions can act on the same operation: the sticky right shift of alignment, and the normalizing shift that follows it (the carry step after an add, or the left shift after a cancellation). The bench drives this with an add whose aligned operand loses a one below the window and whose sum carries out. It also drives a subtraction of a tiny value that collapses to a lone sticky bit and then forces a one-place left shift. In both cases the full 56-bit significand and the exponent are compared against values worked out by hand, so the sticky bit has to survive both shifts.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_class_e;

    // rounding mode code that makes an exact zero negative
    localparam logic [1:0] RM_TO_NEG = 2'd3;

endpackage

// File: rtl/fpsub_lzc.sv
module fpsub_lzc #(
    parameter int W  = 56,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpsub_classify.sv
module fpsub_classify
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int EW    = EXP_W + 2,
    localparam int MW    = FRAC_W + 1,
    localparam int CW    = $clog2(MW + 1)
) (
    input  logic [W-1:0]         op,
    output fp_class_e            cls,
    output logic                 sign,
    output logic signed [EW-1:0] exp_n,
    output logic [MW-1:0]        sig_n
);
    logic [EXP_W-1:0]  e_raw;
    logic [FRAC_W-1:0] f_raw;
    logic [MW-1:0]     sub_sig;
    logic [CW-1:0]     lz;

    assign sign  = op[W-1];
    assign e_raw = op[W-2:FRAC_W];
    assign f_raw = op[FRAC_W-1:0];
    assign sub_sig = {1'b0, f_raw};

    fpsub_lzc #(.W(MW)) u_lzc (.vec(sub_sig), .count(lz));

    always_comb begin
        if (e_raw == '1)
            cls = (f_raw == '0) ? CLS_INF : (f_raw[FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
        else if (e_raw == '0)
            cls = (f_raw == '0) ? CLS_ZERO : CLS_SUB;
        else
            cls = CLS_NORM;
    end

    // subnormals: shift leading one up to the hidden position (R6)
    always_comb begin
        if (e_raw == '0) begin
            sig_n = sub_sig << lz;
            exp_n = EW'(1) - $signed({{(EW-CW){1'b0}}, lz});
        end else begin
            sig_n = {1'b1, f_raw};
            exp_n = $signed({2'b00, e_raw});
        end
    end
endmodule

// File: rtl/fpsub_magpath.sv
module fpsub_magpath #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int EW    = EXP_W + 2,
    localparam int MW    = FRAC_W + 1,
    localparam int SW    = FRAC_W + 4,
    localparam int CW    = $clog2(SW + 1)
) (
    input  logic                 sx,
    input  logic signed [EW-1:0] ex,
    input  logic [MW-1:0]        mx,
    input  logic                 sy_eff,
    input  logic signed [EW-1:0] ey,
    input  logic [MW-1:0]        my,
    output logic                 r_sign,
    output logic signed [EW-1:0] r_exp,
    output logic [SW-1:0]        r_sig,
    output logic                 r_zero
);
    function automatic logic [SW-1:0] shr_sticky(input logic [SW-1:0] v,
                                                 input logic [EW-1:0] d);
        logic [SW-1:0] lost_mask;
        if (d >= EW'(SW)) return {{(SW-1){1'b0}}, |v};
        lost_mask = ~({SW{1'b1}} << d);
        return (v >> d) | {{(SW-1){1'b0}}, |(v & lost_mask)};
    endfunction

    logic [SW-1:0]        ax, ay;
    logic signed [EW-1:0] e_al;
    logic [SW:0]          sum;
    logic [SW-1:0]        dif;
    logic                 dif_sign;
    logic                 eff_add;
    logic [CW-1:0]        lz;

    // alignment with sticky (R7) and magnitude combine
    always_comb begin
        if (ex >= ey) begin
            ax   = {mx, 3'b000};
            ay   = shr_sticky({my, 3'b000}, EW'(ex - ey));
            e_al = ex;
        end else begin
            ax   = shr_sticky({mx, 3'b000}, EW'(ey - ex));
            ay   = {my, 3'b000};
            e_al = ey;
        end
        eff_add = (sx == sy_eff);
        sum     = {1'b0, ax} + {1'b0, ay};
        if (ax >= ay) begin
            dif      = ax - ay;
            dif_sign = sx;
        end else begin
            dif      = ay - ax;
            dif_sign = sy_eff;
        end
    end

    fpsub_lzc #(.W(SW)) u_lzc (.vec(dif), .count(lz));

    // renormalize: one right step on carry (R8), barrel left shift (R9)
    always_comb begin
        r_zero = 1'b0;
        if (eff_add) begin
            r_sign = sx;
            if (sum[SW]) begin
                r_sig = {sum[SW:2], sum[1] | sum[0]};
                r_exp = e_al + EW'(1);
            end else begin
                r_sig = sum[SW-1:0];
                r_exp = e_al;
            end
        end else begin
            r_sign = dif_sign;
            r_zero = (dif == '0);
            r_sig  = dif << lz;
            r_exp  = e_al - $signed({{(EW-CW){1'b0}}, lz});
        end
    end
endmodule

// File: rtl/fpsub_core.sv
module fpsub_core
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int EW    = EXP_W + 2,
    localparam int MW    = FRAC_W + 1,
    localparam int SW    = FRAC_W + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  op_x,
    input  logic [W-1:0]  op_y,
    input  logic [1:0]    rnd_mode,
    output logic          out_valid,
    output logic          res_sign,
    output logic [EW-1:0] res_exp,
    output logic [SW-1:0] res_sig,
    output logic          res_special,
    output logic [W-1:0]  res_bits,
    output logic          res_invalid
);
    localparam logic [W-1:0] INDEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fp_class_e            cx, cy;
    logic                 sx, sy;
    logic signed [EW-1:0] ex, ey;
    logic [MW-1:0]        mx, my;
    logic                 m_sign, m_zero;
    logic signed [EW-1:0] m_exp;
    logic [SW-1:0]        m_sig;
    logic                 nx_special, nx_invalid;
    logic [W-1:0]         nx_bits;
    logic                 neg_zero;

    fpsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_x (
        .op(op_x), .cls(cx), .sign(sx), .exp_n(ex), .sig_n(mx));
    fpsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_y (
        .op(op_y), .cls(cy), .sign(sy), .exp_n(ey), .sig_n(my));

    fpsub_magpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mag (
        .sx(sx), .ex(ex), .mx(mx), .sy_eff(~sy), .ey(ey), .my(my),
        .r_sign(m_sign), .r_exp(m_exp), .r_sig(m_sig), .r_zero(m_zero));

    assign neg_zero = (rnd_mode == RM_TO_NEG);

    // operand-pair table, in priority order (R1..R5, R10)
    always_comb begin
        nx_special = 1'b1;
        nx_invalid = 1'b0;
        nx_bits    = '0;
        if (cy == CLS_SNAN && cx != CLS_SNAN) begin
            nx_invalid = 1'b1;
            nx_bits    = op_y | (W'(1) << (FRAC_W - 1));
        end else if (cx == CLS_SNAN) begin
            nx_invalid = 1'b1;
            nx_bits    = op_x | (W'(1) << (FRAC_W - 1));
        end else if (cy == CLS_QNAN && cx != CLS_QNAN) begin
            nx_bits = op_y;
        end else if (cx == CLS_QNAN) begin
            nx_bits = op_x;
        end else if (cx == CLS_INF && cy == CLS_INF) begin
            if (sx != sy) nx_bits = op_x;
            else begin
                nx_invalid = 1'b1;
                nx_bits    = INDEF;
            end
        end else if (cy == CLS_INF) begin
            nx_bits = {~sy, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cx == CLS_INF) begin
            nx_bits = op_x;
        end else if (cx == CLS_ZERO && cy == CLS_ZERO) begin
            nx_bits = (sx != sy) ? op_x : {neg_zero, {(W-1){1'b0}}};
        end else if (cy == CLS_ZERO) begin
            nx_bits = op_x;
        end else if (cx == CLS_ZERO) begin
            nx_bits = {~sy, op_y[W-2:0]};
        end else if (m_zero) begin
            nx_bits = {neg_zero, {(W-1){1'b0}}};
        end else begin
            nx_special = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            res_sign    <= 1'b0;
            res_exp     <= '0;
            res_sig     <= '0;
            res_special <= 1'b0;
            res_bits    <= '0;
            res_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_sign    <= m_sign;
                res_exp     <= m_exp;
                res_sig     <= m_sig;
                res_special <= nx_special;
                res_bits    <= nx_bits;
                res_invalid <= nx_invalid;
            end
        end
    end

    // R11: one-cycle latency of the valid flag
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: every non-special result is normalized
    p_norm_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_special) |-> res_sig[SW-1]);
    // R12: invalid only ever comes with a bypass result
    p_invalid_bypass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_invalid) |-> res_special);
    // R1: an invalid result is always a quiet NaN
    p_invalid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_invalid) |-> (res_bits[W-2:FRAC_W-1] == '1));
endmodule

// File: tb/fpsub_core_tb_top.sv
module fpsub_core_tb_top;
    typedef struct packed {
        logic [63:0] x;
        logic [63:0] y;
        logic [1:0]  rm;
        logic        byp;
        logic        inv;
        logic [63:0] bval;
        logic        sg;
        logic [12:0] ex;
        logic [55:0] sig;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam logic [55:0] ONE = 56'h80000000000000;
    localparam vec_t VECS [0:NV-1] = '{
        '{64'h4008000000000000, 64'h3FF0000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1024, ONE, 4'd9},               // R9 3-1
        '{64'h3FF0000000000000, 64'hBFF0000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1024, ONE, 4'd8},               // R8 carry
        '{64'h3FF0000000000000, 64'h4008000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b1, 13'd1024, ONE, 4'd9},               // R9 sign of larger
        '{64'h3FF0000000000000, 64'h3C30000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1022, 56'hFFFFFFFFFFFFFE, 4'd7}, // R7 lone sticky
        '{64'h3FF0000000000000, 64'hBFB0000000000001, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1023, 56'h88000000000001, 4'd7}, // R7 sticky add
        '{64'h0000000000000003, 64'h0000000000000001, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'h1FCE, ONE, 4'd6},               // R6 sub-sub
        '{64'h0010000000000000, 64'h0008000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd0, ONE, 4'd6},                  // R6 norm-sub
        '{64'h3FF8000000000000, 64'hBFF8000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1024, 56'hC0000000000000, 4'd8}, // R8
        '{64'h3FFF800000000000, 64'hBFB0000000000001, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 13'd1024, 56'h82000000000001, 4'd8}, // R8 carry+sticky
        '{64'hBFF0000000000000, 64'h3FF0000000000000, 2'd0, 1'b0, 1'b0, 64'h0, 1'b1, 13'd1024, ONE, 4'd8},               // R8 negative
        '{64'h4014000000000000, 64'h4014000000000000, 2'd0, 1'b1, 1'b0, 64'h0000000000000000, 1'b0, 13'd0, 56'h0, 4'd10}, // R10
        '{64'h4014000000000000, 64'h4014000000000000, 2'd3, 1'b1, 1'b0, 64'h8000000000000000, 1'b0, 13'd0, 56'h0, 4'd10}, // R10
        '{64'h3FF0000000000000, 64'h7FF0000000000001, 2'd0, 1'b1, 1'b1, 64'h7FF8000000000001, 1'b0, 13'd0, 56'h0, 4'd1},  // R1
        '{64'hFFF0000000000002, 64'h7FF8000000000000, 2'd0, 1'b1, 1'b1, 64'hFFF8000000000002, 1'b0, 13'd0, 56'h0, 4'd1},  // R1
        '{64'h7FF0000000000003, 64'h7FF0000000000004, 2'd0, 1'b1, 1'b1, 64'h7FF8000000000003, 1'b0, 13'd0, 56'h0, 4'd1},  // R1
        '{64'h7FF8000000000009, 64'hFFF0000000000004, 2'd0, 1'b1, 1'b1, 64'hFFF8000000000004, 1'b0, 13'd0, 56'h0, 4'd1},  // R1
        '{64'h7FF0000000000000, 64'h7FF8000000000005, 2'd0, 1'b1, 1'b0, 64'h7FF8000000000005, 1'b0, 13'd0, 56'h0, 4'd2},  // R2
        '{64'h7FF8000000000007, 64'hFFF8000000000000, 2'd0, 1'b1, 1'b0, 64'h7FF8000000000007, 1'b0, 13'd0, 56'h0, 4'd2},  // R2
        '{64'h7FF8000000000007, 64'h3FF0000000000000, 2'd0, 1'b1, 1'b0, 64'h7FF8000000000007, 1'b0, 13'd0, 56'h0, 4'd2},  // R2
        '{64'h7FF0000000000000, 64'h7FF0000000000000, 2'd0, 1'b1, 1'b1, 64'h7FF8000000000000, 1'b0, 13'd0, 56'h0, 4'd3},  // R3
        '{64'h7FF0000000000000, 64'hFFF0000000000000, 2'd0, 1'b1, 1'b0, 64'h7FF0000000000000, 1'b0, 13'd0, 56'h0, 4'd3},  // R3
        '{64'h3FF0000000000000, 64'h7FF0000000000000, 2'd0, 1'b1, 1'b0, 64'hFFF0000000000000, 1'b0, 13'd0, 56'h0, 4'd3},  // R3
        '{64'hFFF0000000000000, 64'h4000000000000000, 2'd0, 1'b1, 1'b0, 64'hFFF0000000000000, 1'b0, 13'd0, 56'h0, 4'd3},  // R3
        '{64'h0000000000000001, 64'hFFF0000000000000, 2'd0, 1'b1, 1'b0, 64'h7FF0000000000000, 1'b0, 13'd0, 56'h0, 4'd3},  // R3
        '{64'h0000000000000000, 64'h0000000000000000, 2'd0, 1'b1, 1'b0, 64'h0000000000000000, 1'b0, 13'd0, 56'h0, 4'd4},  // R4
        '{64'h0000000000000000, 64'h0000000000000000, 2'd3, 1'b1, 1'b0, 64'h8000000000000000, 1'b0, 13'd0, 56'h0, 4'd4},  // R4
        '{64'h0000000000000000, 64'h8000000000000000, 2'd3, 1'b1, 1'b0, 64'h0000000000000000, 1'b0, 13'd0, 56'h0, 4'd4},  // R4
        '{64'h8000000000000000, 64'h8000000000000000, 2'd2, 1'b1, 1'b0, 64'h0000000000000000, 1'b0, 13'd0, 56'h0, 4'd4},  // R4
        '{64'h4008000000000000, 64'h0000000000000000, 2'd0, 1'b1, 1'b0, 64'h4008000000000000, 1'b0, 13'd0, 56'h0, 4'd5},  // R5
        '{64'h0000000000000000, 64'h4008000000000000, 2'd0, 1'b1, 1'b0, 64'hC008000000000000, 1'b0, 13'd0, 56'h0, 4'd5},  // R5
        '{64'h0000000000000000, 64'h0000000000000005, 2'd0, 1'b1, 1'b0, 64'h8000000000000005, 1'b0, 13'd0, 56'h0, 4'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_x = '0;
    logic [63:0] op_y = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid, res_sign, res_special, res_invalid;
    logic [12:0] res_exp;
    logic [55:0] res_sig;
    logic [63:0] res_bits;
    int          n_checks = 0;
    int          n_errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    fpsub_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .res_sign(res_sign),
        .res_exp(res_exp), .res_sig(res_sig), .res_special(res_special),
        .res_bits(res_bits), .res_invalid(res_invalid));

    task automatic check_bit(input string tag, input logic act, input logic exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp_v);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R11 reset out_valid", out_valid, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_x     = VECS[i].x;
            op_y     = VECS[i].y;
            rnd_mode = VECS[i].rm;
            in_valid = 1'b1;
            @(negedge clk);
            n_checks++;
            if (VECS[i].byp) begin
                if (!out_valid || !res_special || res_bits !== VECS[i].bval
                    || res_invalid !== VECS[i].inv) begin
                    n_errors++;
                    $display("FAIL R%0d vec %0d actual v=%0b sp=%0b bits=%h inv=%0b expected sp=1 bits=%h inv=%0b",
                             VECS[i].req, i, out_valid, res_special, res_bits, res_invalid,
                             VECS[i].bval, VECS[i].inv);
                end
            end else begin
                // R12: finite results carry neither bypass nor invalid
                if (!out_valid || res_special || res_invalid || res_sign !== VECS[i].sg
                    || res_exp !== VECS[i].ex || res_sig !== VECS[i].sig) begin
                    n_errors++;
                    $display("FAIL R%0d vec %0d actual v=%0b sp=%0b inv=%0b s=%0b e=%h m=%h expected s=%0b e=%h m=%h",
                             VECS[i].req, i, out_valid, res_special, res_invalid, res_sign,
                             res_exp, res_sig, VECS[i].sg, VECS[i].ex, VECS[i].sig);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R11 idle out_valid", out_valid, 1'b0);
        // R11: a single presented operation shows up after one edge
        op_x = 64'h4008000000000000;
        op_y = 64'h3FF0000000000000;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R11 single-op out_valid", out_valid, 1'b1);
        check_bit("R12 single-op invalid low", res_invalid, 1'b0);
        @(negedge clk);
        check_bit("R11 single-op drop", out_valid, 1'b0);
        // R11: reset in mid-stream clears the valid flag
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_bit("R11 async reset", out_valid, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule